// File: doc/BRIEF.md
# Dual-Domain Power State Controller

This block moves two independently switchable supply domains, one for the transmit path and one for the receive path, between four system power states. A requester presents a target state on a valid/ready channel. The controller then runs a per-domain sequence that drives the domain's retention sleep control, its isolation enable and the enable of its primary supply switch. It reports the state last reached, a busy flag and an on/off status bit for each domain's rail.

A domain is powered down in two steps. First its sleep control rises, which saves its registers. One cycle later its isolation rises, and that opens the supply switch. Power-up runs the other way. Isolation drops, which closes the switch. After a programmable settle count the sleep control falls, which restores the saved state. If a request changes both domains, the transmit domain is sequenced completely before the receive domain starts. The shared ground is treated as always on.

Back-pressure rules: `req_ready` is high exactly when no sequence is running. A request is taken on a clock edge where `req_valid` and `req_ready` are both high. While `req_ready` is low the requester must hold its request or withdraw it; nothing presented in that window is taken. A request for the state already reached is accepted and completes with no activity.

Top module: `pwr_state_ctl`

## Requirements
- R1: State encoding: bit 0 high means the transmit supply is on, and bit 1 high means the receive supply is on. So 2'b00 is Sleep, 2'b01 is transmit-only, 2'b10 is receive-only and 2'b11 is Duplex. After reset `cur_state` is 2'b00, both isolation enables and both sleep controls are high, both switch enables and both rail status bits are low, and `busy` is low.
- R2: `req_ready` equals the inverse of `busy`. A request is accepted only on an edge where `req_valid` and `req_ready` are both high. Any value on `req_state` while busy has no effect on the sequence or on the final state.
- R3: Each domain's switch enable is high only while that domain's isolation enable is low. Each rail status bit equals that domain's switch enable delayed by one clock.
- R4: Power-down of a domain: its sleep control rises in the cycle after the sequence starts, and its isolation rises one cycle after that.
- R5: Power-up of a domain: its isolation falls in the cycle after the sequence starts, and its sleep control falls SETTLE_CYC cycles later, while the rail status is already on.
- R6: When both domains change, the transmit sequence completes before any receive output moves. The two domains are never both part-way through a sequence.
- R7: `busy` stays high for a number of cycles equal to the sum of the costs of each changing domain: SETTLE_CYC for a power-up, 1 for a power-down. A request for the current state leaves `busy` low and leaves every output unchanged.
- R8: When `busy` falls, `cur_state` equals the accepted request. Each domain's isolation and sleep are low if its bit is set, and high otherwise.
- R9: The ground status output `gnd_ok` is high in every state, including during reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Target state request is valid |
| req_ready | output | 1 | Controller can accept a request |
| req_state | input | 2 | Requested state (R1 encoding) |
| busy | output | 1 | A domain sequence is running |
| cur_state | output | 2 | State last reached |
| tx_iso_en | output | 1 | Transmit domain isolation enable |
| tx_sleep | output | 1 | Transmit domain retention sleep (rise saves, fall restores) |
| tx_sw_en | output | 1 | Transmit primary supply switch enable |
| tx_pwr_ok | output | 1 | Transmit rail status |
| rx_iso_en | output | 1 | Receive domain isolation enable |
| rx_sleep | output | 1 | Receive domain retention sleep |
| rx_sw_en | output | 1 | Receive primary supply switch enable |
| rx_pwr_ok | output | 1 | Receive rail status |
| gnd_ok | output | 1 | Shared ground status |

## Verification
If a domain sequencer holds a wrong state, the fault appears at the ports within one or two cycles of the start of a sequence. It shows up as isolation and sleep moving in the wrong order, as a settle gap of the wrong length, or as the receive domain moving before the transmit domain finishes. If the top-level phase register is wrong, the busy window has the wrong length or `cur_state` settles on a value other than the request. The bench records, for every pair of source and target states, the cycle in which each control and status pin changes. It compares those cycles with the cycles computed from the settle count.

// File: rtl/pwr_state_ctl_pkg.sv
package pwr_state_ctl_pkg;

  // Bit 0: transmit supply on, bit 1: receive supply on.
  typedef enum logic [1:0] {
    PS_SLEEP  = 2'b00,
    PS_TXONLY = 2'b01,
    PS_RXONLY = 2'b10,
    PS_DUPLEX = 2'b11
  } pwr_state_e;

  // Per-domain sequencer phases.
  typedef enum logic [1:0] {
    DS_OFF  = 2'b00,
    DS_WAKE = 2'b01,
    DS_ON   = 2'b10,
    DS_SAVE = 2'b11
  } dom_phase_e;

  // Top-level ordering phases.
  typedef enum logic [1:0] {
    CT_IDLE = 2'b00,
    CT_TX   = 2'b01,
    CT_RX   = 2'b10
  } ctl_phase_e;

endpackage

// File: rtl/pwr_domain_seq.sv
module pwr_domain_seq
  import pwr_state_ctl_pkg::*;
#(
  parameter int SETTLE_CYC = 4,
  localparam int CNT_W = (SETTLE_CYC < 2) ? 1 : $clog2(SETTLE_CYC)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic go_on,
  output logic iso_en,
  output logic sleep,
  output logic done
);

  dom_phase_e       phase_q;
  logic [CNT_W-1:0] cnt_q;
  logic             settle_last;

  assign settle_last = (cnt_q == CNT_W'(SETTLE_CYC - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= DS_OFF;
      cnt_q   <= '0;
    end else begin
      unique case (phase_q)
        DS_OFF: begin
          if (start && go_on) begin
            phase_q <= DS_WAKE;
            cnt_q   <= '0;
          end
        end
        DS_WAKE: begin
          if (settle_last) phase_q <= DS_ON;
          else             cnt_q   <= cnt_q + 1'b1;
        end
        DS_ON: begin
          if (start && !go_on) phase_q <= DS_SAVE;
        end
        DS_SAVE: phase_q <= DS_OFF;
        default: phase_q <= DS_OFF;
      endcase
    end
  end

  // Isolation is held only in the fully off phase; sleep is released only when on.
  assign iso_en = (phase_q == DS_OFF);
  assign sleep  = (phase_q != DS_ON);
  assign done   = ((phase_q == DS_WAKE) && settle_last) || (phase_q == DS_SAVE);

endmodule

// File: rtl/pwr_rail_model.sv
module pwr_rail_model (
  input  logic clk,
  input  logic rst_n,
  input  logic iso_en,
  output logic sw_en,
  output logic pwr_ok
);

  // The supply switch conducts only while isolation is released.
  assign sw_en = ~iso_en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pwr_ok <= 1'b0;
    else        pwr_ok <= sw_en;
  end

endmodule

// File: rtl/pwr_state_ctl.sv
module pwr_state_ctl
  import pwr_state_ctl_pkg::*;
#(
  parameter int SETTLE_CYC = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       req_valid,
  output logic       req_ready,
  input  logic [1:0] req_state,
  output logic       busy,
  output logic [1:0] cur_state,
  output logic       tx_iso_en,
  output logic       tx_sleep,
  output logic       tx_sw_en,
  output logic       tx_pwr_ok,
  output logic       rx_iso_en,
  output logic       rx_sleep,
  output logic       rx_sw_en,
  output logic       rx_pwr_ok,
  output logic       gnd_ok
);

  localparam int NDOM  = 2;
  localparam int TX_IX = 0;
  localparam int RX_IX = 1;

  ctl_phase_e      ctl_q;
  logic [1:0]      tgt_q;
  logic [1:0]      cur_q;
  logic            accept;
  logic [NDOM-1:0] chg_req, chg_tgt;
  logic [NDOM-1:0] d_start, d_go, d_done, d_iso, d_sleep, d_sw, d_ok;

  assign accept  = req_valid && (ctl_q == CT_IDLE);
  assign chg_req = req_state ^ cur_q;
  assign chg_tgt = tgt_q ^ cur_q;

  // Transmit always starts from the accept edge; receive either from accept
  // (when transmit is untouched) or on completion of the transmit sequence.
  assign d_start[TX_IX] = accept && chg_req[TX_IX];
  assign d_start[RX_IX] = (accept && !chg_req[TX_IX] && chg_req[RX_IX]) ||
                          ((ctl_q == CT_TX) && d_done[TX_IX] && chg_tgt[RX_IX]);
  assign d_go[TX_IX]    = req_state[TX_IX];
  assign d_go[RX_IX]    = (ctl_q == CT_IDLE) ? req_state[RX_IX] : tgt_q[RX_IX];

  for (genvar g = 0; g < NDOM; g++) begin : g_dom
    pwr_domain_seq #(.SETTLE_CYC(SETTLE_CYC)) u_seq (
      .clk    (clk),
      .rst_n  (rst_n),
      .start  (d_start[g]),
      .go_on  (d_go[g]),
      .iso_en (d_iso[g]),
      .sleep  (d_sleep[g]),
      .done   (d_done[g])
    );
    pwr_rail_model u_rail (
      .clk    (clk),
      .rst_n  (rst_n),
      .iso_en (d_iso[g]),
      .sw_en  (d_sw[g]),
      .pwr_ok (d_ok[g])
    );
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_q <= CT_IDLE;
      tgt_q <= PS_SLEEP;
      cur_q <= PS_SLEEP;
    end else begin
      unique case (ctl_q)
        CT_IDLE: begin
          if (accept) begin
            tgt_q <= req_state;
            if (chg_req[TX_IX])      ctl_q <= CT_TX;
            else if (chg_req[RX_IX]) ctl_q <= CT_RX;
          end
        end
        CT_TX: begin
          if (d_done[TX_IX]) begin
            if (chg_tgt[RX_IX]) ctl_q <= CT_RX;
            else begin
              ctl_q <= CT_IDLE;
              cur_q <= tgt_q;
            end
          end
        end
        CT_RX: begin
          if (d_done[RX_IX]) begin
            ctl_q <= CT_IDLE;
            cur_q <= tgt_q;
          end
        end
        default: ctl_q <= CT_IDLE;
      endcase
    end
  end

  assign busy      = (ctl_q != CT_IDLE);
  assign req_ready = ~busy;
  assign cur_state = cur_q;
  assign tx_iso_en = d_iso[TX_IX];
  assign tx_sleep  = d_sleep[TX_IX];
  assign tx_sw_en  = d_sw[TX_IX];
  assign tx_pwr_ok = d_ok[TX_IX];
  assign rx_iso_en = d_iso[RX_IX];
  assign rx_sleep  = d_sleep[RX_IX];
  assign rx_sw_en  = d_sw[RX_IX];
  assign rx_pwr_ok = d_ok[RX_IX];
  assign gnd_ok    = 1'b1;

endmodule

// File: rtl/pwr_state_ctl_chk.sv
module pwr_state_ctl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       req_valid,
  input logic       req_ready,
  input logic [1:0] req_state,
  input logic       busy,
  input logic [1:0] cur_state,
  input logic       tx_iso_en,
  input logic       tx_sleep,
  input logic       tx_sw_en,
  input logic       tx_pwr_ok,
  input logic       rx_iso_en,
  input logic       rx_sleep,
  input logic       rx_sw_en,
  input logic       rx_pwr_ok,
  input logic       gnd_ok
);

  // R4: isolation only rises once state has already been saved
  a_r4_tx_save_before_iso: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tx_iso_en) |-> $past(tx_sleep));
  a_r4_rx_save_before_iso: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rx_iso_en) |-> $past(rx_sleep));

  // R5: restore happens with isolation released and rail up
  a_r5_tx_restore_powered: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(tx_sleep) |-> (!tx_iso_en && tx_pwr_ok));
  a_r5_rx_restore_powered: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rx_sleep) |-> (!rx_iso_en && rx_pwr_ok));

  // R3: rail status is never on while the domain is isolated for two cycles
  a_r3_tx_rail_off: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_iso_en && $past(tx_iso_en)) |-> !tx_pwr_ok);
  a_r3_rx_rail_off: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_iso_en && $past(rx_iso_en)) |-> !rx_pwr_ok);

  // R6: at most one domain part-way through a sequence
  a_r6_one_domain_moving: assert property (@(posedge clk) disable iff (!rst_n)
    !((tx_iso_en != tx_sleep) && (rx_iso_en != rx_sleep)));

  // R2: no acceptance while a sequence runs
  a_r2_ready_blocks_busy: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !req_ready);

  // R7: idle with no request stays idle and keeps its state
  a_r7_idle_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !req_valid) |=> (!busy && $stable(cur_state)));

  // R9: ground always reported on
  always_comb begin
    a_r9_ground_on: assert (gnd_ok);
  end

endmodule

bind pwr_state_ctl pwr_state_ctl_chk u_chk (.*);

// File: tb/pwr_state_ctl_bench.sv
module pwr_state_ctl_bench;

  localparam int S   = 3;
  localparam int WIN = 2 * S + 5;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       req_valid = 1'b0;
  logic [1:0] req_state = 2'b00;
  logic       req_ready, busy;
  logic [1:0] cur_state;
  logic       tx_iso_en, tx_sleep, tx_sw_en, tx_pwr_ok;
  logic       rx_iso_en, rx_sleep, rx_sw_en, rx_pwr_ok;
  logic       gnd_ok;

  int n_cmp = 0;
  int n_bad = 0;

  always #5 clk = ~clk;

  pwr_state_ctl #(.SETTLE_CYC(S)) u_pwr_state_ctl (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_state(req_state), .busy(busy), .cur_state(cur_state),
    .tx_iso_en(tx_iso_en), .tx_sleep(tx_sleep), .tx_sw_en(tx_sw_en), .tx_pwr_ok(tx_pwr_ok),
    .rx_iso_en(rx_iso_en), .rx_sleep(rx_sleep), .rx_sw_en(rx_sw_en), .rx_pwr_ok(rx_pwr_ok),
    .gnd_ok(gnd_ok)
  );

  task automatic check(input string tag, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic int cost(input bit chg, input bit up);
    return chg ? (up ? S : 1) : 0;
  endfunction

  // Run one request from the current state to 'to' and check timing per domain.
  task automatic run_req(input logic [1:0] from, input logic [1:0] to);
    int busy_cnt = 0;
    int iso_ev[2], slp_ev[2], ok_ev[2];
    logic [1:0] p_iso, p_slp, p_ok;
    bit [1:0] chg;
    int base[2];
    for (int d = 0; d < 2; d++) begin iso_ev[d] = 0; slp_ev[d] = 0; ok_ev[d] = 0; end
    chg = from ^ to;
    base[0] = 1;
    base[1] = 1 + cost(chg[0], to[0]);
    @(negedge clk);
    check("R2 ready when idle", int'(req_ready), 1);
    p_iso = {rx_iso_en, tx_iso_en};
    p_slp = {rx_sleep, tx_sleep};
    p_ok  = {rx_pwr_ok, tx_pwr_ok};
    req_valid = 1'b1;
    req_state = to;
    for (int n = 1; n <= WIN; n++) begin
      @(negedge clk);
      if (busy) busy_cnt++;
      if (busy && req_ready) check("R2 ready low while busy", 1, 0);
      if (tx_sw_en == tx_iso_en) check("R3 tx switch vs iso", int'(tx_sw_en), int'(!tx_iso_en));
      if (rx_sw_en == rx_iso_en) check("R3 rx switch vs iso", int'(rx_sw_en), int'(!rx_iso_en));
      if (tx_iso_en != p_iso[0]) iso_ev[0] = n;
      if (rx_iso_en != p_iso[1]) iso_ev[1] = n;
      if (tx_sleep  != p_slp[0]) slp_ev[0] = n;
      if (rx_sleep  != p_slp[1]) slp_ev[1] = n;
      if (tx_pwr_ok != p_ok[0])  ok_ev[0]  = n;
      if (rx_pwr_ok != p_ok[1])  ok_ev[1]  = n;
      p_iso = {rx_iso_en, tx_iso_en};
      p_slp = {rx_sleep, tx_sleep};
      p_ok  = {rx_pwr_ok, tx_pwr_ok};
      if (!busy) req_valid = 1'b0;
      else       req_state = ~to;   // must be ignored while busy
    end
    check("R7 busy length", busy_cnt, cost(chg[0], to[0]) + cost(chg[1], to[1]));
    check("R8 cur_state", int'(cur_state), int'(to));
    check("R8 tx iso final", int'(tx_iso_en), int'(!to[0]));
    check("R8 tx sleep final", int'(tx_sleep), int'(!to[0]));
    check("R8 rx iso final", int'(rx_iso_en), int'(!to[1]));
    check("R8 rx sleep final", int'(rx_sleep), int'(!to[1]));
    check("R3 tx rail final", int'(tx_pwr_ok), int'(to[0]));
    check("R3 rx rail final", int'(rx_pwr_ok), int'(to[1]));
    check("R9 ground", int'(gnd_ok), 1);
    for (int d = 0; d < 2; d++) begin
      if (!chg[d]) begin
        check("R7 no-change iso idle", iso_ev[d], 0);
        check("R7 no-change sleep idle", slp_ev[d], 0);
      end else if (to[d]) begin
        check(d == 0 ? "R5 tx iso fall" : "R6 rx iso fall after tx", iso_ev[d], base[d]);
        check("R5 restore after settle", slp_ev[d], base[d] + S);
        check("R3 rail on lag", ok_ev[d], base[d] + 1);
      end else begin
        check(d == 0 ? "R4 tx save" : "R6 rx save after tx", slp_ev[d], base[d]);
        check("R4 iso after save", iso_ev[d], base[d] + 1);
        check("R3 rail off lag", ok_ev[d], base[d] + 2);
      end
    end
  endtask

  initial begin
    logic [1:0] here;
    #12;
    // R1 reset state
    check("R1 reset cur_state", int'(cur_state), 0);
    check("R1 reset tx iso", int'(tx_iso_en), 1);
    check("R1 reset tx sleep", int'(tx_sleep), 1);
    check("R1 reset rx iso", int'(rx_iso_en), 1);
    check("R1 reset rx sleep", int'(rx_sleep), 1);
    check("R1 reset switches", int'({tx_sw_en, rx_sw_en}), 0);
    check("R1 reset rails", int'({tx_pwr_ok, rx_pwr_ok}), 0);
    check("R1 reset busy", int'(busy), 0);
    check("R9 ground in reset", int'(gnd_ok), 1);
    @(negedge clk);
    rst_n = 1'b1;
    here = 2'b00;
    for (int f = 0; f < 4; f++) begin
      for (int t = 0; t < 4; t++) begin
        if (here != 2'(f)) begin
          run_req(here, 2'(f));
          here = 2'(f);
        end
        run_req(here, 2'(t));
        here = 2'(t);
      end
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #1_000_000;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule